// File: doc/BRIEF.md
# Memory-Mapped Switch and Display Bridge

This block sits between a processor's memory port and an external 16-bit SRAM and claims one address in the memory map as an I/O location. Write data from the processor always passes to the SRAM data lines unchanged. A read from the I/O location returns the state of a 16-bit switch bank in place of SRAM data. A write to the I/O location is captured into a 16-bit display register, whose four nibbles drive four hex-digit outputs for an external seven-segment decoder.

All strobes are active-low. An access needs chip enable low. A read is output enable low with write enable high. A write is write enable low. Only the low 16 bits of the 20-bit address are compared against the I/O location, so the location repeats in every 64K page. The two byte-lane strobes select which halves of the display register a write updates. The read path is combinational, so the processor sees its data in the same cycle as the request. The display register changes only on a rising clock edge and is cleared by a synchronous active-high reset.

Top module: `sw_disp_bridge`

## Requirements
- R1: `sram_wdata` equals `cpu_wdata` at all times, whatever the strobes and address.
- R2: During a read (`ce_n`=0, `oe_n`=0, `we_n`=1) with `addr[15:0]` = 16'hFFFF, `cpu_rdata` equals `switch_word` in the same cycle.
- R3: During a read at any other address, `cpu_rdata` equals `sram_rdata` in the same cycle.
- R4: When no read is in progress (`oe_n`=1, or `we_n`=0), `cpu_rdata` is 16'h0000.
- R5: A write (`ce_n`=0, `we_n`=0) with `addr[15:0]` = 16'hFFFF updates the display register at the next rising edge. Bits [7:0] take `cpu_wdata[7:0]` when `lb_n`=0. Bits [15:8] take `cpu_wdata[15:8]` when `ub_n`=0. A lane whose strobe is high keeps its value.
- R6: A write to any other address, or any cycle with no write, leaves the display register unchanged.
- R7: With `rst` high at a rising edge, the display register becomes 16'h0000, and this takes precedence over a write in the same cycle.
- R8: `hex0` shows display bits [3:0], `hex1` bits [7:4], `hex2` bits [11:8] and `hex3` bits [15:12].
- R9: Address bits [19:16] have no effect on I/O decoding, for either reads or writes.
- R10: With `ce_n`=1, `cpu_rdata` is 16'h0000 and the display register does not change, whatever the other strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 20 | Processor address |
| ce_n | input | 1 | Chip enable, active-low |
| ub_n | input | 1 | Upper byte lane enable, active-low |
| lb_n | input | 1 | Lower byte lane enable, active-low |
| oe_n | input | 1 | Output (read) enable, active-low |
| we_n | input | 1 | Write enable, active-low |
| switch_word | input | 16 | Switch bank state |
| cpu_wdata | input | 16 | Write data from the processor |
| sram_rdata | input | 16 | Read data from the SRAM |
| cpu_rdata | output | 16 | Read data returned to the processor |
| sram_wdata | output | 16 | Write data forwarded to the SRAM |
| hex0 | output | 4 | Display digit, bits [3:0] |
| hex1 | output | 4 | Display digit, bits [7:4] |
| hex2 | output | 4 | Display digit, bits [11:8] |
| hex3 | output | 4 | Display digit, bits [15:12] |

## Verification
`cpu_rdata` and `sram_wdata` are due in the same cycle as the request. The bench drives each access on the falling edge and compares these two outputs 1 ns later, before the next rising edge. Display writes and reset show on the hex digits one rising edge after they are presented. The bench updates its own display model at that edge and compares the four digits 1 ns after it. Random traffic is biased toward the I/O location, with random upper address bits and lane strobes. Directed cases cover reset during a write, single-lane writes, and accesses with chip enable high.

// File: rtl/swd_pkg.sv
package swd_pkg;
  // Source chosen for the processor read path
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_MEM  = 2'd1,
    SRC_SW   = 2'd2
  } rd_src_e;
endpackage

// File: rtl/swd_addr_decode.sv
module swd_addr_decode
  import swd_pkg::*;
#(
  parameter int                  ADDR_W  = 20,
  parameter int                  DEC_W   = 16,
  parameter logic [ADDR_W-1:0]   IO_ADDR = 20'h0FFFF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  output rd_src_e           rd_src,
  output logic              wr_io
);
  localparam logic [ADDR_W-1:0] DEC_MASK = {{(ADDR_W-DEC_W){1'b0}}, {DEC_W{1'b1}}};
  localparam logic [ADDR_W-1:0] IO_KEY   = IO_ADDR & DEC_MASK;

  logic io_hit;
  logic rd_act;
  logic wr_act;

  assign io_hit = ((addr & DEC_MASK) == IO_KEY);
  assign rd_act = !ce_n && !oe_n && we_n;
  assign wr_act = !ce_n && !we_n;

  always_comb begin
    if (!rd_act)     rd_src = SRC_NONE;
    else if (io_hit) rd_src = SRC_SW;
    else             rd_src = SRC_MEM;
  end

  assign wr_io = wr_act && io_hit;
endmodule

// File: rtl/swd_read_mux.sv
module swd_read_mux
  import swd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  rd_src_e           rd_src,
  input  logic [DATA_W-1:0] switch_word,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic [DATA_W-1:0] cpu_rdata
);
  always_comb begin
    unique case (rd_src)
      SRC_SW:  cpu_rdata = switch_word;
      SRC_MEM: cpu_rdata = sram_rdata;
      default: cpu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/swd_disp_reg.sv
module swd_disp_reg #(
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  localparam int NLANE = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_io,
  input  logic [NLANE-1:0]  lane_en_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] disp
);
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        disp[g*LANE_W +: LANE_W] <= '0;
      else if (wr_io && !lane_en_n[g])
        disp[g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/sw_disp_bridge.sv
module sw_disp_bridge
  import swd_pkg::*;
#(
  parameter int                ADDR_W  = 20,
  parameter int                DEC_W   = 16,
  parameter int                DIG_W   = 4,
  parameter int                NDIG    = 4,
  parameter logic [ADDR_W-1:0] IO_ADDR = 20'h0FFFF,
  localparam int               DATA_W  = DIG_W * NDIG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [DATA_W-1:0] switch_word,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [DATA_W-1:0] sram_wdata,
  output logic [DIG_W-1:0]  hex0,
  output logic [DIG_W-1:0]  hex1,
  output logic [DIG_W-1:0]  hex2,
  output logic [DIG_W-1:0]  hex3
);
  rd_src_e             rd_src;
  logic                wr_io;
  logic [DATA_W-1:0]   disp;
  logic [DIG_W-1:0]    digit [NDIG];

  swd_addr_decode #(
    .ADDR_W (ADDR_W),
    .DEC_W  (DEC_W),
    .IO_ADDR(IO_ADDR)
  ) i_dec (
    .addr  (addr),
    .ce_n  (ce_n),
    .oe_n  (oe_n),
    .we_n  (we_n),
    .rd_src(rd_src),
    .wr_io (wr_io)
  );

  swd_read_mux #(.DATA_W(DATA_W)) i_rmux (
    .rd_src     (rd_src),
    .switch_word(switch_word),
    .sram_rdata (sram_rdata),
    .cpu_rdata  (cpu_rdata)
  );

  swd_disp_reg #(.DATA_W(DATA_W), .LANE_W(8)) i_disp (
    .clk      (clk),
    .rst      (rst),
    .wr_io    (wr_io),
    .lane_en_n({ub_n, lb_n}),
    .wdata    (cpu_wdata),
    .disp     (disp)
  );

  // Write data goes to memory untouched
  assign sram_wdata = cpu_wdata;

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    assign digit[d] = disp[d*DIG_W +: DIG_W];
  end

  assign hex0 = digit[0];
  assign hex1 = digit[1];
  assign hex2 = digit[2];
  assign hex3 = digit[3];
endmodule

// File: rtl/sw_disp_bridge_chk.sv
module sw_disp_bridge_chk (
  input logic        clk,
  input logic        rst,
  input logic [19:0] addr,
  input logic        ce_n,
  input logic        ub_n,
  input logic        lb_n,
  input logic        oe_n,
  input logic        we_n,
  input logic [15:0] switch_word,
  input logic [15:0] cpu_wdata,
  input logic [15:0] sram_rdata,
  input logic [15:0] cpu_rdata,
  input logic [3:0]  hex0,
  input logic [3:0]  hex1,
  input logic [3:0]  hex2,
  input logic [3:0]  hex3
);
  logic rd, wr, io;
  assign rd = !ce_n && !oe_n && we_n;
  assign wr = !ce_n && !we_n;
  assign io = (addr[15:0] == 16'hFFFF);

  AST_READ_SWITCH: assert property (@(posedge clk) disable iff (rst)
    rd && io |-> cpu_rdata == switch_word); // R2
  AST_READ_MEMORY: assert property (@(posedge clk) disable iff (rst)
    rd && !io |-> cpu_rdata == sram_rdata); // R3
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd |-> cpu_rdata == 16'h0000); // R4
  AST_LOW_LANE_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr && io && !lb_n |=> {hex1, hex0} == $past(cpu_wdata[7:0])); // R5
  AST_HIGH_LANE_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr && io && !ub_n |=> {hex3, hex2} == $past(cpu_wdata[15:8])); // R5
  AST_DISPLAY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr && io) |=> $stable({hex3, hex2, hex1, hex0})); // R6
endmodule

bind sw_disp_bridge sw_disp_bridge_chk i_chk (
  .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .ub_n(ub_n), .lb_n(lb_n),
  .oe_n(oe_n), .we_n(we_n), .switch_word(switch_word), .cpu_wdata(cpu_wdata),
  .sram_rdata(sram_rdata), .cpu_rdata(cpu_rdata),
  .hex0(hex0), .hex1(hex1), .hex2(hex2), .hex3(hex3)
);

// File: tb/test_sw_disp_bridge.sv
`timescale 1ns/1ps
module test_sw_disp_bridge;
  logic        clk = 1'b0;
  logic        rst;
  logic [19:0] addr;
  logic        ce_n, ub_n, lb_n, oe_n, we_n;
  logic [15:0] switch_word, cpu_wdata, sram_rdata;
  logic [15:0] cpu_rdata, sram_wdata;
  logic [3:0]  hex0, hex1, hex2, hex3;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] model = 16'h0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sw_disp_bridge i_sw_disp_bridge (
    .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .ub_n(ub_n), .lb_n(lb_n),
    .oe_n(oe_n), .we_n(we_n), .switch_word(switch_word), .cpu_wdata(cpu_wdata),
    .sram_rdata(sram_rdata), .cpu_rdata(cpu_rdata), .sram_wdata(sram_wdata),
    .hex0(hex0), .hex1(hex1), .hex2(hex2), .hex3(hex3)
  );

  function automatic logic [15:0] exp_rd(logic [19:0] a, logic ce, logic oe, logic we,
                                         logic [15:0] sw, logic [15:0] mem);
    if (ce || oe || !we) return 16'h0000;
    return (a[15:0] == 16'hFFFF) ? sw : mem;
  endfunction

  function automatic logic [15:0] exp_disp(logic [15:0] old, logic r, logic [19:0] a,
                                           logic ce, logic we, logic ub, logic lb,
                                           logic [15:0] wd);
    logic [15:0] n = old;
    if (r) return 16'h0000;
    if (!ce && !we && a[15:0] == 16'hFFFF) begin
      if (!lb) n[7:0]  = wd[7:0];
      if (!ub) n[15:8] = wd[15:8];
    end
    return n;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive on the falling edge, check combinational outputs, then the digits after the edge
  task automatic step(logic r, logic [19:0] a, logic ce, logic ub, logic lb, logic oe,
                      logic we, logic [15:0] sw, logic [15:0] wd, logic [15:0] mem,
                      string rtag, string dtag);
    @(negedge clk);
    rst = r; addr = a; ce_n = ce; ub_n = ub; lb_n = lb; oe_n = oe; we_n = we;
    switch_word = sw; cpu_wdata = wd; sram_rdata = mem;
    #1;
    check(rtag, cpu_rdata, exp_rd(a, ce, oe, we, sw, mem));
    check("R1", sram_wdata, wd);
    model = exp_disp(model, r, a, ce, we, ub, lb, wd);
    @(posedge clk);
    #1;
    check(dtag, {hex3, hex2, hex1, hex0}, model);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; addr = '0; ce_n = 1; ub_n = 1; lb_n = 1; oe_n = 1; we_n = 1;
    switch_word = '0; cpu_wdata = '0; sram_rdata = '0;
    repeat (2) @(posedge clk);
    #1;
    check("R7 reset state", {hex3, hex2, hex1, hex0}, 16'h0000);
    model = 16'h0;

    // Directed: switch read, memory read, idle, write idle (R2 R3 R4)
    step(0, 20'h0FFFF, 0, 0, 0, 0, 1, 16'hA5C3, 16'h1111, 16'h2222, "R2", "R6");
    step(0, 20'h01234, 0, 0, 0, 0, 1, 16'hA5C3, 16'h1111, 16'h2222, "R3", "R6");
    step(0, 20'h0FFFF, 0, 0, 0, 1, 1, 16'hA5C3, 16'h1111, 16'h2222, "R4", "R6");
    // Full write to I/O, digit order (R5 R8)
    step(0, 20'h0FFFF, 0, 0, 0, 1, 0, 16'h0, 16'h4321, 16'h0, "R4", "R5");
    check("R8 hex0", {12'h0, hex0}, 16'h0001);
    check("R8 hex3", {12'h0, hex3}, 16'h0004);
    // Single lanes (R5)
    step(0, 20'h0FFFF, 0, 1, 0, 1, 0, 16'h0, 16'hBEEF, 16'h0, "R4", "R5 low lane");
    step(0, 20'h0FFFF, 0, 0, 1, 1, 0, 16'h0, 16'hCAFE, 16'h0, "R4", "R5 high lane");
    // Write elsewhere ignored (R6)
    step(0, 20'h0FFFE, 0, 0, 0, 1, 0, 16'h0, 16'h0000, 16'h0, "R4", "R6");
    // Upper address bits ignored (R9)
    step(0, 20'hAFFFF, 0, 0, 0, 0, 1, 16'h7E57, 16'h0, 16'h3333, "R9 read", "R6");
    step(0, 20'h5FFFF, 0, 0, 0, 1, 0, 16'h0, 16'h9876, 16'h0, "R4", "R9 write");
    // Chip enable high blocks everything (R10)
    step(0, 20'h0FFFF, 1, 0, 0, 0, 1, 16'hFFFF, 16'h0, 16'hFFFF, "R10 read", "R6");
    step(0, 20'h0FFFF, 1, 0, 0, 0, 0, 16'h0, 16'h1357, 16'h0, "R10 read", "R10 write");
    // Reset beats a write (R7)
    step(1, 20'h0FFFF, 0, 0, 0, 1, 0, 16'h0, 16'hFFFF, 16'h0, "R4", "R7 reset over write");

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [19:0] a;
      a = $urandom();
      if ($urandom_range(0, 2) != 0) a[15:0] = 16'hFFFF;
      step(($urandom_range(0, 99) == 0), a, ($urandom_range(0, 7) == 0),
           1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()),
           16'($urandom()), 16'($urandom()), 16'($urandom()),
           "R2 R3 R4 random read", "R5 R6 R7 random display");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    done = 1'b1;
    $finish;
  end
endmodule